// File: doc/BRIEF.md
# Serial ROM-Code CRC-8 Engine

This block checks a 64-bit device identity code as it arrives one bit at a time. The code has three parts. The low byte is a family byte. The next 48 bits are a serial number. The top byte is a check byte. Each bit that is presented with a valid strobe goes into an 8-bit division register. The register is built from the polynomial x^8 + x^5 + x^4 + 1 and takes bits least significant first.

When the 56th bit has been taken, the register holds the check byte for the family and serial fields. The block copies it into an output register, so it can also be used to generate a check byte. When the 64th bit has been taken, the whole frame has been divided and the frame is marked complete. A valid frame leaves the register at zero.

The block also collects the first eight bits into a byte and compares that byte with an expected family value. After a complete frame, further bits are dropped until the engine is cleared. The clear can come from the synchronous active-low reset or from a synchronous clear input.

Top module: `rom_code_crc8`

## Requirements
- R1: In the cycle after `rst_n` is low or `clr` is high, `rem`, `crc_byte` and `bit_cnt` are all 0, and `done`, `crc_ok` and `family_ok` are all low.
- R2: A bit is accepted when `bit_vld` is high, `done` is low and `clr` is low. For each accepted bit, let fb = `bit_din` XOR `rem[0]`. The next `rem` is (`rem` >> 1) XOR (fb ? 8'h8C : 8'h00), and `bit_cnt` increases by one.
- R3: In a cycle with `bit_vld` low, `rem`, `bit_cnt`, `crc_byte` and `family_ok` keep their values.
- R4: On the 56th accepted bit, `crc_byte` takes the new value of `rem`, which is the CRC of code bits 0..55 sent LSB first. It keeps that value until the next clear.
- R5: `done` goes high on the 64th accepted bit, and `bit_cnt` then reads 64. Before that, `done` stays low.
- R6: `crc_ok` is high exactly when `done` is high and `rem` is zero. A correct frame gives 1. A frame with any single bit flipped gives 0.
- R7: `family_ok` is high only once at least 8 bits have been accepted. It also needs the first 8 bits, assembled with the first bit as bit 0, to equal `FAMILY_EXP` (default 8'h21).
- R8: While `done` is high, offered bits change neither `rem`, `bit_cnt` nor `crc_byte`.
- R9: When `clr` and `bit_vld` are both high in the same cycle, the clear wins and the bit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear; restarts the frame |
| bit_vld | input | 1 | Strobe qualifying `bit_din` |
| bit_din | input | 1 | Serial data bit, LSB first |
| rem | output | 8 | Current division remainder |
| bit_cnt | output | 7 | Number of accepted bits |
| crc_byte | output | 8 | Remainder captured after the 56th bit |
| done | output | 1 | All 64 bits accepted |
| crc_ok | output | 1 | Frame complete with zero remainder |
| family_ok | output | 1 | First byte matches `FAMILY_EXP` |

## Verification
The bench builds the engine with its default parameters: an 8-bit remainder, the reflected constant 8'h8C, a 64-bit frame with a 56-bit data field, and an expected family of 8'h21. These defaults let the vector table run full frames against an independent byte-wise CRC model. One vector is a known published identity code whose check byte is A2h. Other frames have a single bit flipped in the family, serial or check field, and each of these must fail the zero-remainder test. Some of them must also drop the family match. With the count limits at their default values, the directed tests can reach frame completion, bits offered after completion, and a clear arriving in the same cycle as a bit.

// File: rtl/crc8_pkg.sv
// Package: shared frame constants and the control phase type for the
// serial identity-code CRC engine. Assumes an LSB-first bit stream.
package crc8_pkg;
    localparam int DEF_CRC_W       = 8;
    localparam int DEF_FRAME_BITS  = 64;
    localparam int DEF_DATA_BITS   = 56;
    localparam int DEF_FAMILY_BITS = 8;

    // Position of the frame, derived from the accepted-bit count.
    typedef enum logic [1:0] {
        PH_FAMILY = 2'd0,
        PH_SERIAL = 2'd1,
        PH_CHECK  = 2'd2,
        PH_DONE   = 2'd3
    } frame_phase_e;
endpackage

// File: rtl/crc8_shift_stage.sv
// Module: combinational single-bit step of a right-shifting (reflected)
// CRC register. Assumes POLY holds the reflected polynomial with the
// x^W term dropped; bit i of POLY sets a feedback tap into position i.
module crc8_shift_stage #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    POLY = 8'h8C
) (
    input  logic [W-1:0] cur,
    input  logic         din,
    output logic [W-1:0] nxt
);
    logic fb;

    // Feedback is the incoming bit against the bit leaving the register.
    always_comb fb = din ^ cur[0];

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == W - 1) begin : g_top
            // Top position receives only the feedback term.
            always_comb nxt[i] = fb & POLY[i];
        end else begin : g_mid
            // Lower positions take the neighbour above plus an optional tap.
            always_comb nxt[i] = cur[i+1] ^ (fb & POLY[i]);
        end
    end
endmodule

// File: rtl/crc8_seq_ctrl.sv
// Module: counts accepted bits, decides acceptance, raises the capture
// strobe on the last data bit and the done flag on the last frame bit.
// Assumes DATA_BITS < FRAME_BITS and FAMILY_BITS <= DATA_BITS.
module crc8_seq_ctrl
    import crc8_pkg::*;
#(
    parameter int FRAME_BITS  = DEF_FRAME_BITS,
    parameter int DATA_BITS   = DEF_DATA_BITS,
    parameter int FAMILY_BITS = DEF_FAMILY_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_vld,
    output logic             accept,
    output logic             cap_crc,
    output logic             fam_phase,
    output logic             fam_full,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    frame_phase_e phase;

    // Bits are taken only when valid, not complete, and not being cleared.
    always_comb accept = bit_vld & ~done & ~clr;

    // Frame phase decoded from the count.
    always_comb begin
        if (done)                                phase = PH_DONE;
        else if (cnt < CNT_W'(FAMILY_BITS))      phase = PH_FAMILY;
        else if (cnt < CNT_W'(DATA_BITS))        phase = PH_SERIAL;
        else                                     phase = PH_CHECK;
    end

    // Phase-derived strobes for the datapath.
    always_comb begin
        fam_phase = (phase == PH_FAMILY);
        fam_full  = (phase != PH_FAMILY);
        cap_crc   = accept && (cnt == CNT_W'(DATA_BITS - 1));
    end

    // Accepted-bit counter and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (accept) begin
            cnt  <= cnt + 1'b1;
            done <= (cnt == CNT_W'(FRAME_BITS - 1));
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_BITS)); // R5
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bit_vld && !clr) |=> (done && $stable(cnt))); // R8
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && bit_vld) |=> (cnt == '0 && !done)); // R9
endmodule

// File: rtl/crc8_remainder.sv
// Module: holds the division remainder and the captured check byte.
// Assumes the controller gives accept and cap_crc in the same cycle as
// the bit that causes them.
module crc8_remainder #(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 8'h8C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         accept,
    input  logic         cap_crc,
    input  logic         din,
    output logic [W-1:0] rem,
    output logic [W-1:0] crc_byte
);
    logic [W-1:0] rem_nxt;

    crc8_shift_stage #(.W(W), .POLY(POLY)) u_stage (
        .cur (rem),
        .din (din),
        .nxt (rem_nxt)
    );

    // Remainder register: advances one step per accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  rem <= '0;
        else if (accept)    rem <= rem_nxt;
    end

    // Check-byte register: loads the remainder after the last data bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  crc_byte <= '0;
        else if (cap_crc)   crc_byte <= rem_nxt;
    end

    AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !clr) |=> $stable(rem)); // R3
    AST_REM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rem == '0 && crc_byte == '0)); // R1
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_crc && !clr) |=> $stable(crc_byte)); // R4
endmodule

// File: rtl/crc8_family_cap.sv
// Module: assembles the first FAMILY_BITS accepted bits, first bit as
// bit 0, and compares them with the expected family value. Assumes
// the controller marks the family phase and its completion.
module crc8_family_cap #(
    parameter int                   FAMILY_BITS = 8,
    parameter logic [FAMILY_BITS-1:0] EXPECT    = 8'h21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic accept,
    input  logic fam_phase,
    input  logic fam_full,
    input  logic din,
    output logic match
);
    logic [FAMILY_BITS-1:0] fam;

    // Shift register filled from the top so the first bit ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            fam <= '0;
        else if (accept && fam_phase) fam <= {din, fam[FAMILY_BITS-1:1]};
    end

    // Match is only meaningful once the whole byte is in.
    always_comb match = fam_full && (fam == EXPECT);

    AST_FAM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fam_full && $past(fam_full) && !clr) |-> $stable(fam)); // R7
endmodule

// File: rtl/rom_code_crc8.sv
// Module: top of the serial identity-code CRC engine. Ties the control,
// remainder and family-capture pieces together. Assumes one bit per
// strobed cycle, least significant bit first, family byte first.
module rom_code_crc8
    import crc8_pkg::*;
#(
    parameter int                       CRC_W       = DEF_CRC_W,
    parameter logic [CRC_W-1:0]         POLY_REFL   = 8'h8C,
    parameter int                       FRAME_BITS  = DEF_FRAME_BITS,
    parameter int                       DATA_BITS   = DEF_DATA_BITS,
    parameter int                       FAMILY_BITS = DEF_FAMILY_BITS,
    parameter logic [FAMILY_BITS-1:0]   FAMILY_EXP  = 8'h21,
    localparam int                      CNT_W       = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_din,
    output logic [CRC_W-1:0] rem,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [CRC_W-1:0] crc_byte,
    output logic             done,
    output logic             crc_ok,
    output logic             family_ok
);
    logic accept;
    logic cap_crc;
    logic fam_phase;
    logic fam_full;

    crc8_seq_ctrl #(
        .FRAME_BITS  (FRAME_BITS),
        .DATA_BITS   (DATA_BITS),
        .FAMILY_BITS (FAMILY_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .bit_vld   (bit_vld),
        .accept    (accept),
        .cap_crc   (cap_crc),
        .fam_phase (fam_phase),
        .fam_full  (fam_full),
        .cnt       (bit_cnt),
        .done      (done)
    );

    crc8_remainder #(.W(CRC_W), .POLY(POLY_REFL)) u_rem (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .accept   (accept),
        .cap_crc  (cap_crc),
        .din      (bit_din),
        .rem      (rem),
        .crc_byte (crc_byte)
    );

    crc8_family_cap #(.FAMILY_BITS(FAMILY_BITS), .EXPECT(FAMILY_EXP)) u_fam (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .accept    (accept),
        .fam_phase (fam_phase),
        .fam_full  (fam_full),
        .din       (bit_din),
        .match     (family_ok)
    );

    // Frame verdict: complete and divided down to zero.
    always_comb crc_ok = done && (rem == '0);

    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> done); // R6
    AST_FAM_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        family_ok |-> (bit_cnt >= CNT_W'(FAMILY_BITS))); // R7
    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !done && !clr) |=> (bit_cnt == $past(bit_cnt) + 1'b1)); // R2
endmodule

// File: tb/rom_code_crc8_bench.sv
module rom_code_crc8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_din = 1'b0;
    logic [7:0] rem;
    logic [6:0] bit_cnt;
    logic [7:0] crc_byte;
    logic       done;
    logic       crc_ok;
    logic       family_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rom_code_crc8 u_rom_code_crc8 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld), .bit_din(bit_din),
        .rem(rem), .bit_cnt(bit_cnt), .crc_byte(crc_byte), .done(done),
        .crc_ok(crc_ok), .family_ok(family_ok)
    );

    // Vector: [63:56] bit index to flip (FF = none), [55:8] serial, [7:0] family.
    localparam int NV = 8;
    localparam logic [63:0] VEC [NV] = '{
        {8'hFF, 48'h0000_0001_B81C, 8'h02},
        {8'hFF, 48'h0000_1234_5678, 8'h21},
        {8'hFF, 48'hFFFF_FFFF_FFFF, 8'h21},
        {8'hFF, 48'h0000_0000_0000, 8'h21},
        {8'd0,  48'hA5A5_5A5A_C3C3, 8'h21},
        {8'd30, 48'h0000_1234_5678, 8'h21},
        {8'd60, 48'h0000_1234_5678, 8'h21},
        {8'd63, 48'h8000_0000_0001, 8'h10}
    };

    // Byte-wise reference CRC over seven bytes, low byte first.
    function automatic logic [7:0] ref_crc(input logic [55:0] d);
        logic [7:0] c = 8'h00;
        for (int b = 0; b < 7; b++) begin
            c = c ^ d[b*8 +: 8];
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
        end
        return c;
    endfunction

    // One-bit reference step used for directed checks.
    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic d);
        return (d ^ c[0]) ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1; bit_vld = 1'b0;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic send(input logic b);
        @(negedge clk); bit_vld = 1'b1; bit_din = b;
    endtask

    task automatic idle();
        @(negedge clk); bit_vld = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] code;
        logic [7:0]  crc, flip, r;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "rem after reset", rem, 0);
        check("R1", "cnt after reset", bit_cnt, 0);
        check("R1", "flags after reset", {done, crc_ok, family_ok, crc_byte}, 0);
        rst_n = 1'b1;

        // Table walk: full frames against the reference model.
        for (int v = 0; v < NV; v++) begin
            flip = VEC[v][63:56];
            crc  = ref_crc(VEC[v][55:0]);
            code = {crc, VEC[v][55:0]};
            if (flip != 8'hFF) code[flip] = ~code[flip];
            if (v == 0) check("R4", "known code check byte", crc, 8'hA2);
            do_clear();
            for (int i = 0; i < 64; i++) begin
                send(code[i]);
                if (i == 56) begin
                    // Sampled here: 56 bits accepted so far.
                    check("R4", "crc_byte after 56 bits", crc_byte, ref_crc(code[55:0]));
                end
                if (i == 63) check("R5", "done low before bit 64", done, 0);
            end
            idle();
            check("R5", "done after 64", done, 1);
            check("R5", "count after 64", bit_cnt, 64);
            check("R4", "crc_byte held", crc_byte, ref_crc(code[55:0]));
            check("R6", "crc_ok verdict", crc_ok, flip == 8'hFF);
            check("R7", "family match", family_ok, code[7:0] == 8'h21);
            if (flip == 8'hFF) begin
                // R8: bits after completion are ignored.
                for (int i = 0; i < 6; i++) send(1'b1);
                idle();
                check("R8", "count after extra bits", bit_cnt, 64);
                check("R8", "rem after extra bits", rem, 0);
                check("R8", "crc_byte after extra bits", crc_byte, crc);
            end
        end

        // R2 single steps from zero.
        do_clear();
        check("R1", "clear state", {rem, bit_cnt, done, family_ok, crc_byte}, 0);
        send(1'b1); idle();
        check("R2", "step with 1", rem, 8'h8C);
        send(1'b0); idle();
        check("R2", "step with 0", rem, 8'h46);
        check("R2", "count after two", bit_cnt, 2);

        // R3 stall with strobe low.
        r = 8'h46;
        send(1'b1); send(1'b1); send(1'b0);
        r = ref_step(ref_step(ref_step(r, 1'b1), 1'b1), 1'b0);
        idle(); repeat (4) @(negedge clk);
        check("R3", "rem stable while idle", rem, r);
        check("R3", "count stable while idle", bit_cnt, 5);
        check("R3", "family_ok stable while idle", family_ok, 0);

        // R7 partial family byte 21h.
        do_clear();
        for (int i = 0; i < 7; i++) send(i == 0 || i == 5);
        idle();
        check("R7", "family_ok before 8 bits", family_ok, 0);
        send(1'b0); idle();
        check("R7", "family_ok at 8 bits", family_ok, 1);

        // R9 clear and strobe together.
        @(negedge clk); clr = 1'b1; bit_vld = 1'b1; bit_din = 1'b1;
        @(negedge clk); clr = 1'b0; bit_vld = 1'b0;
        check("R9", "count after clr with bit", bit_cnt, 0);
        check("R9", "rem after clr with bit", rem, 0);
        check("R9", "family after clr with bit", family_ok, 0);

        // R1 reset mid-frame.
        send(1'b1); send(1'b1); idle();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1", "reset mid-frame", {rem, bit_cnt, done}, 0);

        summary();
    end
endmodule